// File: doc/BRIEF.md
# Variable-Length Serial Shift Port

This block is the shifting core of a synchronous serial port. A serial clock has already been selected and brought into the system clock domain as two single-cycle strobes. One strobe marks a rising edge and the other marks a falling edge. The transmit side accepts a parallel word through a ready/load handshake. It then drives that word onto the serial data output, one bit per rising strobe, most significant bit first.

The receive side samples the serial data input on every falling strobe and shifts it in from the right. Each time a full word has been collected, the receive side copies that word into a receive buffer, right-justified, and raises a valid flag. A read pulse clears the valid flag. A word that completes while the previous one is still unread raises an overrun flag.

The word length is chosen from four settings: 8, 16, 24 or 32 bits. The transmit side runs a state machine with the states TX_IDLE, TX_ARMED and TX_SHIFT:

- TX_IDLE goes to TX_ARMED on a load.
- TX_ARMED goes to TX_SHIFT on the first rising strobe, which also puts out the first bit.
- TX_SHIFT either puts out the next bit on each rising strobe, or goes back to TX_IDLE on the rising strobe that ends the last bit.

The receive side runs a state machine with the states RX_COLLECT and RX_COMMIT:

- RX_COLLECT goes to RX_COMMIT on the falling strobe that brings in the last bit of a word.
- RX_COMMIT always goes back to RX_COLLECT after one cycle. In that cycle it writes the buffer and the flags, and it still accepts a falling strobe as the first bit of the next word.

Top module: `sps_core`

## Requirements
- R1: `sd_out` changes only on a clock edge at which `ser_rise` is sampled high; with no rising strobe it holds its value.
- R2: The word length is 8, 16, 24 or 32 bits for `len_sel` values 0, 1, 2 and 3. It is latched when a transmit word is loaded. The transmitted bits are bit length-1 of `tx_data` first, down to bit 0 last, each driven for one serial period.
- R3: `tx_ready` is high only in TX_IDLE. A `tx_load` is accepted only while `tx_ready` is high, and `tx_ready` drops at the next edge. A rising strobe in the accepting cycle is ignored, so the first bit appears on the next rising strobe. `tx_ready` returns high at the rising strobe that ends the last bit.
- R4: `sd_in` is sampled at each edge with `ser_fall` high and enters the receive shift register at bit 0, with earlier bits moving left. The length is latched from `len_sel` at the first bit of each word. The edge after the last bit is sampled copies the word to `rx_word`.
- R5: `rx_word` holds the first received bit of a word at bit length-1 and the last at bit 0, with every bit from length upward equal to 0.
- R6: `rx_valid` rises with each new `rx_word` and falls at the edge after an `rx_read` pulse, unless a new word is committed at that same edge.
- R7: `rx_overrun` rises when a word is committed while `rx_valid` is high and `rx_read` is low. The new word overwrites the buffer, and the flag stays high until an `rx_read` pulse.
- R8: After reset `sd_out`, `rx_word`, `rx_valid` and `rx_overrun` are 0, and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_sel | input | 2 | Word length select: 0=8, 1=16, 2=24, 3=32 bits |
| ser_rise | input | 1 | Rising-edge strobe of the serial clock |
| ser_fall | input | 1 | Falling-edge strobe of the serial clock |
| tx_data | input | 32 | Word to transmit |
| tx_load | input | 1 | Load pulse for `tx_data` |
| tx_ready | output | 1 | Transmitter can accept a word |
| sd_out | output | 1 | Serial data output |
| sd_in | input | 1 | Serial data input |
| rx_word | output | 32 | Receive buffer, right-justified |
| rx_valid | output | 1 | Receive buffer holds an unread word |
| rx_read | input | 1 | Read pulse, clears valid and overrun |
| rx_overrun | output | 1 | A word was overwritten before being read |

## Verification
- A transmit bit is due on `sd_out` immediately after the edge that samples the rising strobe.
- `tx_ready` drops one edge after an accepted load and returns at the rising strobe that ends the last bit.
- A received word, with its valid and overrun flags, lands one edge after the edge that samples the word's last falling strobe.
- The bench model advances on the same edges with the same inputs, which it drives half a cycle before each edge. It compares all five outputs on the falling system clock edge, so every expected value is already due whenever it is compared.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_SHIFT = 2'd2
    } tx_state_t;

    typedef enum logic {
        RX_COLLECT = 1'b0,
        RX_COMMIT  = 1'b1
    } rx_state_t;

    // Number of bits per word for a length select code; step is W/4.
    function automatic int word_bits(input logic [1:0] sel, input int step);
        return step * (int'(sel) + 1);
    endfunction

endpackage

// File: rtl/sps_tx.sv
module sps_tx
    import sps_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   len_sel,
    input  logic         ser_rise,
    input  logic [W-1:0] tx_data,
    input  logic         tx_load,
    output logic         tx_ready,
    output logic         sd_out
);
    localparam int STEP = W / 4;
    localparam int CW   = $clog2(W + 1);

    tx_state_t      state_q, state_d;
    logic [W-1:0]   shreg_q;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  len_q;
    logic [CW-1:0]  load_len;
    logic           last_bit;

    assign load_len = CW'(word_bits(len_sel, STEP));
    assign last_bit = (cnt_q == len_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (tx_load)  state_d = TX_ARMED;
            TX_ARMED: if (ser_rise) state_d = TX_SHIFT;
            TX_SHIFT: if (ser_rise && last_bit) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            len_q   <= CW'(W);
            sd_out  <= 1'b0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (tx_load) begin
                        // left-align so bit len-1 sits at the top
                        shreg_q <= tx_data << (W - int'(load_len));
                        len_q   <= load_len;
                        cnt_q   <= '0;
                    end
                end
                TX_ARMED: begin
                    if (ser_rise) begin
                        sd_out  <= shreg_q[W-1];
                        shreg_q <= shreg_q << 1;
                        cnt_q   <= CW'(1);
                    end
                end
                TX_SHIFT: begin
                    if (ser_rise && !last_bit) begin
                        sd_out  <= shreg_q[W-1];
                        shreg_q <= shreg_q << 1;
                        cnt_q   <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign tx_ready = (state_q == TX_IDLE);

    AST_TX_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_rise |=> $stable(sd_out)); // R1
    AST_TX_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && tx_load) |=> !tx_ready); // R3
    AST_TX_RISE_IGNORED_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && tx_load) |=> (cnt_q == '0)); // R3
    AST_TX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SHIFT) |-> (cnt_q >= CW'(1) && cnt_q <= len_q)); // R2

endmodule

// File: rtl/sps_rx.sv
module sps_rx
    import sps_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   len_sel,
    input  logic         ser_fall,
    input  logic         sd_in,
    input  logic         rx_read,
    output logic [W-1:0] rx_word,
    output logic         rx_valid,
    output logic         rx_overrun
);
    localparam int STEP = W / 4;
    localparam int CW   = $clog2(W + 1);

    rx_state_t      state_q, state_d;
    logic [W-1:0]   shreg_q;
    logic [W-1:0]   shreg_nx;
    logic [W-1:0]   done_q;
    logic [W-1:0]   len_mask;
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  len_q;
    logic [CW-1:0]  cur_len;
    logic           word_end;

    // length is taken live on the first bit, latched afterwards
    assign cur_len  = (cnt_q == '0) ? CW'(word_bits(len_sel, STEP)) : len_q;
    assign shreg_nx = {shreg_q[W-2:0], sd_in};
    assign word_end = ser_fall && ((cnt_q + 1'b1) == cur_len);
    assign len_mask = {W{1'b1}} >> (W - int'(cur_len));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_COLLECT;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_COLLECT: if (word_end) state_d = RX_COMMIT;
            RX_COMMIT:  state_d = RX_COLLECT;
            default:    state_d = RX_COLLECT;
        endcase
    end

    // shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            len_q   <= CW'(W);
            done_q  <= '0;
        end else if (ser_fall) begin
            shreg_q <= shreg_nx;
            if (cnt_q == '0) len_q <= cur_len;
            if (word_end) begin
                done_q <= shreg_nx & len_mask;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    // receive buffer and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word    <= '0;
            rx_valid   <= 1'b0;
            rx_overrun <= 1'b0;
        end else begin
            unique case (state_q)
                RX_COMMIT: begin
                    rx_word    <= done_q;
                    rx_valid   <= 1'b1;
                    rx_overrun <= (rx_overrun || rx_valid) && !rx_read;
                end
                RX_COLLECT: begin
                    if (rx_read) begin
                        rx_valid   <= 1'b0;
                        rx_overrun <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_RX_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != RX_COMMIT) |=> $stable(rx_word)); // R4
    AST_RX_VALID_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_COMMIT) |=> rx_valid); // R6
    AST_RX_OVR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $past(rx_valid)); // R7
    AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_read && state_q == RX_COLLECT) |=> (!rx_valid && !rx_overrun)); // R6
    AST_RX_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_COMMIT) |=> (state_q == RX_COLLECT)); // R4
    AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_COMMIT && len_q == CW'(STEP)) |=> (rx_word[W-1:STEP] == '0)); // R5

endmodule

// File: rtl/sps_core.sv
module sps_core
    import sps_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   len_sel,
    input  logic         ser_rise,
    input  logic         ser_fall,
    input  logic [W-1:0] tx_data,
    input  logic         tx_load,
    output logic         tx_ready,
    output logic         sd_out,
    input  logic         sd_in,
    output logic [W-1:0] rx_word,
    output logic         rx_valid,
    input  logic         rx_read,
    output logic         rx_overrun
);

    sps_tx #(.W(W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .len_sel  (len_sel),
        .ser_rise (ser_rise),
        .tx_data  (tx_data),
        .tx_load  (tx_load),
        .tx_ready (tx_ready),
        .sd_out   (sd_out)
    );

    sps_rx #(.W(W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_sel    (len_sel),
        .ser_fall   (ser_fall),
        .sd_in      (sd_in),
        .rx_read    (rx_read),
        .rx_word    (rx_word),
        .rx_valid   (rx_valid),
        .rx_overrun (rx_overrun)
    );

endmodule

// File: tb/sps_core_test.sv
module sps_core_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   len_sel = 2'd0;
    logic         ser_rise = 1'b0;
    logic         ser_fall = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         tx_load = 1'b0;
    logic         tx_ready;
    logic         sd_out;
    logic         sd_in = 1'b0;
    logic [W-1:0] rx_word;
    logic         rx_valid;
    logic         rx_read = 1'b0;
    logic         rx_overrun;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit loopback = 1'b1;
    bit read_en = 1'b1;
    bit done = 1'b0;

    sps_core #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .len_sel(len_sel),
        .ser_rise(ser_rise), .ser_fall(ser_fall),
        .tx_data(tx_data), .tx_load(tx_load), .tx_ready(tx_ready),
        .sd_out(sd_out), .sd_in(sd_in),
        .rx_word(rx_word), .rx_valid(rx_valid), .rx_read(rx_read),
        .rx_overrun(rx_overrun)
    );

    always #10 clk = ~clk; // 50 MHz

    // ---------------- reference model ----------------
    bit      m_q[$];
    bit      m_busy = 0;
    bit      m_sd = 0;
    longint  m_acc = 0;
    int      m_cnt = 0;
    int      m_len = 8;
    bit      m_pend = 0;
    longint  m_pval = 0;
    longint  m_word = 0;
    bit      m_valid = 0;
    bit      m_ovr = 0;

    function automatic int bits_of(input logic [1:0] s);
        return 8 * (int'(s) + 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete(); m_busy = 0; m_sd = 0; m_acc = 0; m_cnt = 0;
            m_pend = 0; m_word = 0; m_valid = 0; m_ovr = 0;
        end else begin
            bit was_ready;
            bit commit;
            was_ready = !m_busy;
            // transmit side
            if (ser_rise) begin
                if (m_q.size() > 0) m_sd = m_q.pop_front();
                else if (m_busy)   m_busy = 0;
            end
            if (was_ready && tx_load) begin
                int n;
                n = bits_of(len_sel);
                for (int i = n - 1; i >= 0; i--) m_q.push_back(tx_data[i]);
                m_busy = 1;
            end
            // receive buffer commit from word ended on the previous edge
            commit = m_pend;
            m_pend = 0;
            m_ovr   = (m_ovr && !rx_read) || (commit && m_valid && !rx_read);
            m_valid = commit || (m_valid && !rx_read);
            if (commit) m_word = m_pval;
            // receive shifting
            if (ser_fall) begin
                if (m_cnt == 0) m_len = bits_of(len_sel);
                m_acc = (m_acc << 1) | longint'(sd_in);
                m_cnt++;
                if (m_cnt == m_len) begin
                    m_pval = m_acc & ((longint'(1) << m_len) - 1);
                    m_pend = 1;
                    m_cnt = 0;
                    m_acc = 0;
                end
            end
        end
    end

    // ---------------- comparison on the falling system edge ----------------
    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            chk("R1/R2", "sd_out", longint'(sd_out), longint'(m_sd));
            chk("R3", "tx_ready", longint'(tx_ready), longint'(!m_busy));
            chk("R4/R5", "rx_word", longint'(rx_word), m_word);
            chk("R6", "rx_valid", longint'(rx_valid), longint'(m_valid));
            chk("R7", "rx_overrun", longint'(rx_overrun), longint'(m_ovr));
        end
    end

    // ---------------- serial clock strobes and stimulus ----------------
    int  gap = 2;
    bit  phase_hi = 0;
    always @(negedge clk) begin
        ser_rise <= 1'b0;
        ser_fall <= 1'b0;
        if (rst_n) begin
            if (gap == 0) begin
                if (phase_hi) ser_fall <= 1'b1;
                else          ser_rise <= 1'b1;
                phase_hi <= !phase_hi;
                gap <= 2 + int'($urandom_range(0, 2));
            end else begin
                gap <= gap - 1;
            end
        end
        sd_in   <= loopback ? sd_out : 1'($urandom_range(0, 1));
        rx_read <= read_en && ($urandom_range(0, 5) == 0);
    end

    task automatic send(input logic [W-1:0] d);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = d;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R8: reset values
        chk("R8", "sd_out reset", longint'(sd_out), 0);
        chk("R8", "tx_ready reset", longint'(tx_ready), 1);
        chk("R8", "rx_word reset", longint'(rx_word), 0);
        chk("R8", "rx_valid reset", longint'(rx_valid), 0);
        chk("R8", "rx_overrun reset", longint'(rx_overrun), 0);
        rst_n = 1'b1;
        // R2/R4/R5: each length, loopback, assorted patterns
        for (int s = 0; s < 4; s++) begin
            len_sel = 2'(s);
            send(32'hA5C3_0FF1);
            send(32'hFFFF_FFFF);
            send(32'h0000_0001);
            send(32'h8000_0000);
            for (int k = 0; k < 4; k++) send($urandom);
        end
        // R7: no reads, overrun builds up
        read_en = 1'b0;
        len_sel = 2'd0;
        for (int k = 0; k < 8; k++) send($urandom);
        read_en = 1'b1;
        repeat (200) @(negedge clk);
        // R4: independent random receive stream, length changes
        loopback = 1'b0;
        for (int s = 0; s < 4; s++) begin
            len_sel = 2'(3 - s);
            repeat (600) @(negedge clk);
        end
        // R3: back-to-back loads with mixed lengths
        loopback = 1'b1;
        for (int k = 0; k < 12; k++) begin
            len_sel = 2'($urandom_range(0, 3));
            send($urandom);
        end
        repeat (400) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule